// File: doc/BRIEF.md
# Open-Drain Manchester Blink Transmitter

This block sends a short diagnostic message by blinking an LED that hangs on a shared open-drain pin. It never drives the pin high: its only output is a pull-low enable, taken straight from a flip-flop so that every release and pull is clean. An optical sensor watching the LED can then recover the message off the board.

Software first checks that the block is not busy. It then writes a 32-bit message word, and finally writes the control fields together with a start bit. The control fields are a byte-count code and a speed code. The block first sends a fixed lock-on pattern. It then sends the selected bytes in Manchester code and holds the pin released for a guard period. Only after that does it drop busy. The speed code scales a base tick count, so the shortest half-bit interval can be set to a microsecond or longer.

Top module: `blink_ser_tx`

## Requirements
- R1: After reset, `pull_low` is 0 and `busy` is 0.
- R2: Every frame starts with eight lock-on bits, seven 1s then one 0, ahead of any message bit; the pin is released in the first half-interval after start.
- R3: `ctl_len` code n (0..3) sends n+1 bytes taken from `wr_data[31:24]` downward; the highest byte goes first and each byte goes MSB first.
- R4: A 1 bit is released (`pull_low`=0) in its first half-interval and pulled (`pull_low`=1) in its second; a 0 bit is pulled then released.
- R5: A half-interval lasts `BASE_TICKS << ctl_rate` clock cycles, using the rate captured with the accepted start.
- R6: After the last message bit the pin stays released for four half-intervals, and `busy` stays 1 until that guard ends. `busy` is high for exactly (2*(8+8*(n+1))+4) half-intervals.
- R7: `pull_low` is 0 whenever `busy` is 0, and it changes only at half-interval boundaries.
- R8: A start (`wr_ctl_en` with `ctl_go`=1) while `busy` is 1 is ignored; the running frame and its timing are unchanged.
- R9: A message-word write while `busy` is 1 is ignored, and the stored word is kept for later frames; a word write in the same cycle as an accepted start is the word that frame sends.
- R10: `busy` reads 1 from the cycle after a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_en | input | 1 | Write strobe for the message word |
| wr_data | input | 32 | Message word |
| wr_ctl_en | input | 1 | Write strobe for the control fields |
| ctl_len | input | 2 | Byte count code (n+1 bytes) |
| ctl_rate | input | 2 | Speed code, half-interval = BASE_TICKS << code |
| ctl_go | input | 1 | Start bit, acted on with `wr_ctl_en` |
| busy | output | 1 | Frame in progress, including the guard period |
| pull_low | output | 1 | Open-drain pull-low enable for the pin |

## Verification
The message-word write and the start of a frame can land in the same clock cycle. The bench provokes this by raising `wr_data_en` and `wr_ctl_en` with `ctl_go` together while the block is idle. It then compares every half-interval of the pin against the pattern built from that same word, so a stale stored word would show up at once. The opposite case is a word write and a start during a running frame. Both must leave the frame and the end of busy untouched, and a later frame sent without a new write must still carry the original word.

// File: rtl/blink_pkg.sv
package blink_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_TAIL = 2'd2
   } blink_st_e;

   localparam logic [7:0] LOCK_PAT   = 8'hFE;
   localparam int         GUARD_HALF = 4;
endpackage

// File: rtl/blink_interval.sv
module blink_interval #(
   parameter int BASE_TICKS = 100,
   parameter int RATE_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int NRATE   = 1 << RATE_W;
   localparam int MAX_INT = BASE_TICKS << (NRATE - 1);
   localparam int CW      = $clog2(MAX_INT + 1);

   logic [CW-1:0] lim_tab [NRATE];
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   for (genvar r = 0; r < NRATE; r++) begin : g_lim
      assign lim_tab[r] = CW'(BASE_TICKS << r);
   end

   assign lim  = lim_tab[rate];
   assign tick = run && (cnt == lim - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (tick)       cnt <= '0;
      else                 cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/blink_frame.sv
module blink_frame
   import blink_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              shift,
   output logic              cur_bit,
   output logic              next_bit,
   output logic              last_bit
);
   localparam int SR_W = DATA_W + 8;
   localparam int RM_W = $clog2(SR_W + 1);

   logic [SR_W-1:0] sr;
   logic [RM_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr     <= '0;
         remain <= '0;
      end else if (load) begin
         sr     <= {LOCK_PAT, load_data};
         remain <= RM_W'(16) + (RM_W'(load_len) << 3);
      end else if (shift) begin
         sr     <= sr << 1;
         remain <= remain - RM_W'(1);
      end
   end

   assign cur_bit  = sr[SR_W-1];
   assign next_bit = sr[SR_W-2];
   assign last_bit = (remain == RM_W'(1));
endmodule

// File: rtl/blink_ser_tx.sv
module blink_ser_tx
   import blink_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int RATE_W     = 2,
   parameter int BASE_TICKS = 100
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_data_en,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        wr_ctl_en,
   input  logic [$clog2(DATA_W/8)-1:0] ctl_len,
   input  logic [RATE_W-1:0]           ctl_rate,
   input  logic                        ctl_go,
   output logic                        busy,
   output logic                        pull_low
);
   localparam int NBYTES = DATA_W / 8;
   localparam int LEN_W  = $clog2(NBYTES);
   localparam int GC_W   = $clog2(GUARD_HALF);

   if (DATA_W % 8 != 0 || NBYTES < 2) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (BASE_TICKS < 1) begin : g_bad_ticks
      $error("BASE_TICKS must be positive");
   end

   blink_st_e         state;
   logic [DATA_W-1:0] data_q;
   logic [RATE_W-1:0] rate_q;
   logic              half;
   logic [GC_W-1:0]   guard_cnt;
   logic              tick;
   logic              go_ok;
   logic              cur_bit, next_bit, last_bit;
   logic              do_shift;
   logic [DATA_W-1:0] frame_src;

   assign go_ok     = wr_ctl_en && ctl_go && (state == ST_IDLE);
   assign frame_src = wr_data_en ? wr_data : data_q;
   assign do_shift  = (state == ST_SEND) && tick && half && !last_bit;
   assign busy      = (state != ST_IDLE);

   blink_interval #(.BASE_TICKS(BASE_TICKS), .RATE_W(RATE_W)) u_interval (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .rate (rate_q),
      .tick (tick)
   );

   blink_frame #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go_ok),
      .load_data(frame_src),
      .load_len (ctl_len),
      .shift    (do_shift),
      .cur_bit  (cur_bit),
      .next_bit (next_bit),
      .last_bit (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 data_q <= '0;
      else if (wr_data_en && state == ST_IDLE)    data_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rate_q    <= '0;
         half      <= 1'b0;
         guard_cnt <= '0;
         pull_low  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               pull_low <= 1'b0;
               if (go_ok) begin
                  state    <= ST_SEND;
                  rate_q   <= ctl_rate;
                  half     <= 1'b0;
                  pull_low <= ~LOCK_PAT[7];
               end
            end
            ST_SEND: begin
               if (tick) begin
                  if (!half) begin
                     half     <= 1'b1;
                     pull_low <= cur_bit;
                  end else if (last_bit) begin
                     state     <= ST_TAIL;
                     guard_cnt <= '0;
                     pull_low  <= 1'b0;
                  end else begin
                     half     <= 1'b0;
                     pull_low <= ~next_bit;
                  end
               end
            end
            ST_TAIL: begin
               pull_low <= 1'b0;
               if (tick) begin
                  if (guard_cnt == GC_W'(GUARD_HALF - 1)) state <= ST_IDLE;
                  else guard_cnt <= guard_cnt + GC_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/blink_ser_tx_chk.sv
module blink_ser_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic pull_low,
   input logic tick,
   input logic wr_ctl_en,
   input logic ctl_go
);
   a_r7_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pull_low);

   a_r7_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull_low) |-> $past(tick));

   a_r6_released_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!pull_low && !$past(pull_low)));

   a_r2_start_released: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !pull_low);

   a_r10_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_ctl_en && ctl_go) |=> busy);
endmodule

bind blink_ser_tx blink_ser_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .pull_low (pull_low),
   .tick     (tick),
   .wr_ctl_en(wr_ctl_en),
   .ctl_go   (ctl_go)
);

// File: tb/tb_blink_ser_tx.sv
module tb_blink_ser_tx;
   localparam int BASE = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_data_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        wr_ctl_en = 1'b0;
   logic [1:0]  ctl_len = '0;
   logic [1:0]  ctl_rate = '0;
   logic        ctl_go = 1'b0;
   logic        busy;
   logic        pull_low;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   blink_ser_tx #(.DATA_W(32), .RATE_W(2), .BASE_TICKS(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .wr_data_en(wr_data_en), .wr_data(wr_data),
      .wr_ctl_en(wr_ctl_en), .ctl_len(ctl_len), .ctl_rate(ctl_rate),
      .ctl_go(ctl_go), .busy(busy), .pull_low(pull_low)
   );

   // {data, len code, rate code}
   localparam logic [35:0] VEC [5] = '{
      {32'h5A00_0000, 2'd0, 2'd0},
      {32'hA5C3_0F01, 2'd3, 2'd1},
      {32'h0000_FFFF, 2'd1, 2'd2},
      {32'hFFFF_FF81, 2'd2, 2'd0},
      {32'h8001_7E00, 2'd3, 2'd3}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit exp_pull(input logic [31:0] d, input int len, input int k);
      int nb = 8 + 8 * (len + 1);
      int b;
      bit v;
      if (k >= 2 * nb) return 1'b0;
      b = k / 2;
      if (b < 8) v = (b < 7);
      else v = d[31 - (b - 8)];
      return (k % 2 == 0) ? !v : v;
   endfunction

   task automatic send(input logic [31:0] d, input bit wr_d, input logic [1:0] len,
                       input logic [1:0] rate, input logic [31:0] ed, input bit disturb);
      int t  = BASE << rate;
      int nb = 8 + 8 * (int'(len) + 1);
      int h  = 2 * nb + 4;
      @(negedge clk);
      wr_data_en = wr_d; wr_data = d; wr_ctl_en = 1'b1; ctl_len = len;
      ctl_rate = rate; ctl_go = 1'b1;
      @(negedge clk);
      wr_data_en = 1'b0; wr_ctl_en = 1'b0; ctl_go = 1'b0;
      for (int c = 0; c <= h * t; c++) begin
         if (c == 0) check(busy == 1'b1, "R10 busy after go", busy, 1);
         if (c % t == t / 2 && c / t < h) begin
            int k = c / t;
            bit e = exp_pull(ed, int'(len), k);
            if (k < 16)          check(pull_low == e, "R2 lock-on half", pull_low, e);
            else if (k < 2 * nb) check(pull_low == e, "R3 R4 R5 data half", pull_low, e);
            else                 check(pull_low == e, "R6 guard released", pull_low, e);
         end
         if (c == h * t - 1) check(busy == 1'b1, "R6 busy through guard", busy, 1);
         if (c == h * t) begin
            check(busy == 1'b0, "R6 busy clears after guard", busy, 0);
            check(pull_low == 1'b0, "R7 released when idle", pull_low, 0);
         end
         wr_data_en = 1'b0; wr_ctl_en = 1'b0; ctl_go = 1'b0;
         if (disturb && c == 5 * t) begin
            // R8 R9: start and word write mid-frame must be ignored
            wr_data_en = 1'b1; wr_data = 32'h0000_0000;
            wr_ctl_en = 1'b1; ctl_go = 1'b1; ctl_len = 2'd0; ctl_rate = 2'd0;
         end
         @(negedge clk);
      end
      wr_data_en = 1'b0; wr_ctl_en = 1'b0; ctl_go = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 reset busy", busy, 0);
      check(pull_low == 1'b0, "R1 reset pull_low", pull_low, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pull_low == 1'b0, "R1 idle after reset", pull_low, 0);

      // vector walk: word write and start in the same cycle (R9)
      for (int i = 0; i < 5; i++) begin
         send(VEC[i][35:4], 1'b1, VEC[i][3:2], VEC[i][1:0], VEC[i][35:4], 1'b0);
         repeat (3) @(negedge clk);
      end

      // word loaded ahead of start, then start without a word write (R9)
      @(negedge clk);
      wr_data_en = 1'b1; wr_data = 32'hC3A5_0000;
      @(negedge clk);
      wr_data_en = 1'b0;
      send(32'h0, 1'b0, 2'd1, 2'd1, 32'hC3A5_0000, 1'b0);

      // mid-frame start and word write ignored (R8, R9)
      send(32'h96E1_7F3C, 1'b1, 2'd3, 2'd1, 32'h96E1_7F3C, 1'b1);
      // stored word survives the ignored write (R9)
      send(32'h0, 1'b0, 2'd3, 2'd0, 32'h96E1_7F3C, 1'b0);

      // quiet idle: pin never pulled without a frame (R7)
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (pull_low || busy) check(1'b0, "R7 idle quiet", pull_low, 0);
      end
      check(pull_low == 1'b0, "R7 idle quiet end", pull_low, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule